// File: doc/BRIEF.md
# Microcoded single-bus fetch-and-add controller

This block is the control and datapath core of a small processor built around one shared data bus. A microcode store of 32 words, each 20 bits wide, sequences every step: each word carries load strobes for the instruction register, the two ALU operand latches and the memory address register, four bus-driver enables (register file, ALU, memory and immediate), a register selector, a register write strobe, an ALU operation bit, a memory write strobe and a next-address field. Every control in a word takes effect at the rising clock edge that ends that step.

Only three routines are implemented. The fetch routine reads the instruction at the program counter, advances the counter by four and dispatches on the opcode. A no-operation routine returns straight to fetch. The fetch-and-add routine is an atomic read-modify-write. Its memory address comes from register rd. Its sum is written back to that word, and the old memory word is returned in register rs. Memory sits outside the block and answers a read in the same cycle, with no wait states.

Top module: `ucode_bus_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mem_we` is 0 and `mem_addr` is 0. Reset clears the program counter to 0 and loads each register i with REG_BASE + 4*i, where REG_BASE is 0x200 by default.
- R2: Fetch takes three cycles. In the first, the address register and operand A are loaded from the program counter. In the second, the instruction register is loaded from memory at that address. In the third, A+4 is written to the program counter and the opcode is dispatched. As a result, `mem_addr` equals the address of the instruction being fetched during the second fetch cycle.
- R3: An instruction word holds the opcode in bits 31:26, the source register rs in bits 25:21 and the destination register rd in bits 15:11. Opcode 0x3C selects fetch-and-add, and opcode 0x00 selects no-operation.
- R4: For fetch-and-add, let old be the memory word at address R[rd]. The instruction stores old + R[rs] (the value rs held before the instruction) at that address and leaves old in R[rs].
- R5: Fetch-and-add runs four microsteps after fetch, so each such instruction takes 7 cycles. The memory write happens only in its fourth microstep, with `mem_addr` equal to R[rd]. The instruction register does not change while the routine runs.
- R6: A no-operation runs one microstep and jumps back to fetch, so each takes 4 cycles and changes no memory.
- R7: Any opcode other than 0x3C behaves exactly like a no-operation.
- R8: No microstep enables more than one bus driver.
- R9: Fetch-and-add changes no register other than rs, and does not change the program counter.
- R10: When rd equals rs, fetch-and-add still stores old + (the original R[rs]) and leaves old in that register.
- R11: `mem_we` is high only in the last microstep of a fetch-and-add. The next microstep is the first fetch step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 32 | Memory word at `mem_addr`, valid in the same cycle |
| mem_addr | output | 32 | Byte address held in the memory address register |
| mem_wdata | output | 32 | Bus value written to memory when `mem_we` is high |
| mem_we | output | 1 | Memory write strobe, applied at the rising edge |

## Verification
The embedded assertions check the following on every cycle:
- at most one bus driver is enabled;
- the program counter steps by four only at dispatch and holds during fetch-and-add;
- dispatch lands on one of the two routines;
- the instruction register holds through fetch-and-add;
- the address register holds R[rd] before the read;
- the write strobe is always followed by fetch.

Only the bench scenarios can show the end-to-end arithmetic. They check the old value returned in rs, the sum stored in memory, the rd-equals-rs case, the cycle cost of each instruction, the handling of undefined opcodes, and that no other register was disturbed. A reference model compares these after instruction streams, with register values read back through later fetch-and-add results.

// File: rtl/ucode_bus_core.sv
module ucode_bus_core #(
  parameter int          DW       = 32,
  parameter int          NREG     = 32,
  parameter int          UAW      = 5,
  parameter logic [5:0]  OP_XADD  = 6'h3C,
  parameter logic [DW-1:0] REG_BASE = 32'h0000_0200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);
  localparam int RW = $clog2(NREG);
  localparam int UW = 15 + UAW;

  localparam logic [1:0] SEL_PC = 2'd0, SEL_RS = 2'd1, SEL_RD = 2'd2;
  localparam logic [1:0] BR_NEXT = 2'd0, BR_JUMP = 2'd1, BR_DISP = 2'd2;
  localparam logic       OP_INC4 = 1'b0, OP_ADD = 1'b1;

  localparam logic [UAW-1:0] U_F0  = UAW'(0);
  localparam logic [UAW-1:0] U_F1  = UAW'(1);
  localparam logic [UAW-1:0] U_F2  = UAW'(2);
  localparam logic [UAW-1:0] U_NOP = UAW'(3);
  localparam logic [UAW-1:0] U_X0  = UAW'(4);
  localparam logic [UAW-1:0] U_X1  = UAW'(5);
  localparam logic [UAW-1:0] U_X2  = UAW'(6);
  localparam logic [UAW-1:0] U_X3  = UAW'(7);

  function automatic logic [UW-1:0] mk(
    input logic ldir, input logic [1:0] sel, input logic wr, input logic enr,
    input logic lda, input logic ldb, input logic aop, input logic enalu,
    input logic ldma, input logic mwr, input logic enm, input logic eni,
    input logic [1:0] br, input logic [UAW-1:0] tgt);
    return {ldir, sel, wr, enr, lda, ldb, aop, enalu, ldma, mwr, enm, eni, br, tgt};
  endfunction

  function automatic logic [UW-1:0] urom(input logic [UAW-1:0] a);
    case (a)
      U_F0:  urom = mk(0, SEL_PC, 0, 1, 1, 0, OP_INC4, 0, 1, 0, 0, 0, BR_NEXT, U_F0);
      U_F1:  urom = mk(1, SEL_PC, 0, 0, 0, 0, OP_INC4, 0, 0, 0, 1, 0, BR_NEXT, U_F0);
      U_F2:  urom = mk(0, SEL_PC, 1, 0, 0, 0, OP_INC4, 1, 0, 0, 0, 0, BR_DISP, U_F0);
      U_NOP: urom = mk(0, SEL_PC, 0, 0, 0, 0, OP_INC4, 0, 0, 0, 0, 0, BR_JUMP, U_F0);
      U_X0:  urom = mk(0, SEL_RD, 0, 1, 0, 0, OP_INC4, 0, 1, 0, 0, 0, BR_NEXT, U_F0);
      U_X1:  urom = mk(0, SEL_RS, 0, 1, 0, 1, OP_INC4, 0, 0, 0, 0, 0, BR_NEXT, U_F0);
      U_X2:  urom = mk(0, SEL_RS, 1, 0, 1, 0, OP_INC4, 0, 0, 0, 1, 0, BR_NEXT, U_F0);
      U_X3:  urom = mk(0, SEL_PC, 0, 0, 0, 0, OP_ADD,  1, 0, 1, 0, 0, BR_JUMP, U_F0);
      default: urom = mk(0, SEL_PC, 0, 0, 0, 0, OP_INC4, 0, 0, 0, 0, 0, BR_JUMP, U_F0);
    endcase
  endfunction

  function automatic logic [UAW-1:0] dispatch(input logic [5:0] op);
    return (op == OP_XADD) ? U_X0 : U_NOP;
  endfunction

  logic [UAW-1:0] upc;
  logic [UW-1:0]  uw;
  logic [DW-1:0]  pc, ir, a_q, b_q, ma_q, bus, alu, imm, rf_out;
  logic [DW-1:0]  rf [NREG];
  logic [RW-1:0]  ridx;

  assign uw = urom(upc);

  logic           ld_ir, reg_wr, en_reg, ld_a, ld_b, alu_op, en_alu, ld_ma, mem_wr, en_mem, en_imm;
  logic [1:0]     reg_sel, ubr;
  logic [UAW-1:0] utgt;

  assign {ld_ir, reg_sel, reg_wr, en_reg, ld_a, ld_b, alu_op, en_alu,
          ld_ma, mem_wr, en_mem, en_imm, ubr, utgt} = uw;

  wire [RW-1:0] f_rs = ir[25 -: RW];
  wire [RW-1:0] f_rd = ir[15 -: RW];

  assign ridx   = (reg_sel == SEL_RS) ? f_rs : f_rd;
  assign rf_out = (reg_sel == SEL_PC) ? pc : rf[ridx];
  assign alu    = (alu_op == OP_ADD) ? a_q + b_q : a_q + DW'(4);
  assign imm    = {{(DW-21){ir[20]}}, ir[20:0]};

  assign bus = en_reg ? rf_out :
               en_alu ? alu    :
               en_mem ? mem_rdata :
               en_imm ? imm    : '0;

  assign mem_addr  = ma_q;
  assign mem_wdata = bus;
  assign mem_we    = mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      upc  <= U_F0;
      pc   <= '0;
      ir   <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= REG_BASE + DW'(4 * i);
    end else begin
      if (ld_ir) ir   <= bus;
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
      if (reg_wr) begin
        if (reg_sel == SEL_PC) pc <= bus;
        else                   rf[ridx] <= bus;
      end
      case (ubr)
        BR_JUMP: upc <= utgt;
        BR_DISP: upc <= dispatch(ir[31:26]);
        default: upc <= upc + UAW'(1);
      endcase
    end
  end

  wire in_xadd = (upc >= U_X0) && (upc <= U_X3);

  p_one_driver_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_reg, en_alu, en_mem, en_imm}));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (upc == U_F2) |=> (pc == $past(pc) + DW'(4)));

  p_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    (upc == U_F2) |=> (upc == U_X0 || upc == U_NOP));

  p_nop_return_r6: assert property (@(posedge clk) disable iff (rst)
    (upc == U_NOP) |=> (upc == U_F0));

  p_ir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    in_xadd |=> $stable(ir));

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    in_xadd |=> $stable(pc));

  p_addr_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (upc == U_X1) |-> (ma_q == rf[f_rd]));

  p_write_last_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (upc == U_F0));
endmodule

// File: tb/tb_ucode_bus_core.sv
module tb_ucode_bus_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] XADD = 6'h3C;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we;

  logic [31:0] mem  [256];
  logic [31:0] rmem [256];
  logic [31:0] rreg [32];
  int checks = 0, fails = 0, we_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_bus_core dut (.clk(clk), .rst(rst), .mem_rdata(mem_rdata),
                      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we));

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (!rst && mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      we_count <= we_count + 1;
    end
  end

  function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rd);
    return {op, 5'(rs), 5'd0, 5'(rd), 11'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_all;
    rst = 1;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = (i >= 128 && i < 160) ? 32'h0000_0100 + 32'(i * 7) : 32'h0;
      rmem[i] = mem[i];
    end
    for (int i = 0; i < 32; i++) rreg[i] = 32'h200 + 32'(4 * i);
    repeat (2) @(posedge clk);
    #1 we_count = 0;
  endtask

  task automatic put(input int idx, input logic [31:0] w);
    mem[idx]  = w;
    rmem[idx] = w;
  endtask

  task automatic ref_exec(input logic [31:0] w);
    logic [31:0] old, addr, s;
    if (w[31:26] == XADD) begin
      addr = rreg[w[15:11]];
      old  = rmem[addr[9:2]];
      s    = rreg[w[25:21]];
      rreg[w[25:21]] = old;
      rmem[addr[9:2]] = old + s;
    end
  endtask

  task automatic release_rst;
    @(negedge clk) rst = 0;
  endtask

  task automatic to_cycle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    init_all();
    #1;
    chk("R1 we in reset", {31'd0, mem_we}, 32'd0);
    chk("R1 addr in reset", mem_addr, 32'd0);
    release_rst();
    to_cycle(1);
    chk("R1 addr first fetch", mem_addr, 32'd0);
  endtask

  task automatic t_nop_stream;
    init_all();
    put(0, enc(6'h00, 0, 0)); put(1, enc(6'h00, 3, 4)); put(2, enc(6'h00, 0, 0));
    release_rst();
    to_cycle(1);  chk("R2 fetch addr instr0", mem_addr, 32'd0);
    to_cycle(4);  chk("R6 fetch addr instr1", mem_addr, 32'd4);
    to_cycle(4);  chk("R6 fetch addr instr2", mem_addr, 32'd8);
    to_cycle(8);
    chk("R6 no writes", 32'(we_count), 32'd0);
    chk("R6 data unchanged", mem[131], rmem[131]);
  endtask

  task automatic t_single_xadd;
    logic [31:0] old;
    init_all();
    put(0, enc(XADD, 5, 3));
    old = mem[131];
    release_rst();
    to_cycle(4); chk("R4 address from rd", mem_addr, 32'h20C);
    to_cycle(1); chk("R5 no early write", {31'd0, mem_we}, 32'd0);
    to_cycle(1);
    chk("R5 write in fourth step", {31'd0, mem_we}, 32'd1);
    chk("R5 write address", mem_addr, 32'h20C);
    chk("R4 write data", mem_wdata, old + 32'h214);
    to_cycle(1);
    chk("R11 strobe drops", {31'd0, mem_we}, 32'd0);
    chk("R4 memory sum", mem[131], old + 32'h214);
    to_cycle(1); chk("R2 next fetch addr", mem_addr, 32'd4);
  endtask

  task automatic t_chain;
    logic [31:0] prog [8];
    prog[0] = enc(XADD, 5, 3);
    prog[1] = enc(6'h00, 0, 0);
    prog[2] = enc(XADD, 6, 4);
    prog[3] = enc(XADD, 9, 9);
    prog[4] = enc(6'h15, 9, 2);
    prog[5] = enc(XADD, 5, 7);
    prog[6] = enc(XADD, 9, 8);
    prog[7] = enc(XADD, 2, 1);
    init_all();
    for (int i = 0; i < 8; i++) put(i, prog[i]);
    for (int i = 0; i < 8; i++) ref_exec(prog[i]);
    release_rst();
    to_cycle(52);
    for (int i = 128; i < 160; i++) chk("R4 R9 R10 data word", mem[i], rmem[i]);
    chk("R11 write count", 32'(we_count), 32'd6);
    for (int i = 0; i < 8; i++) chk("R9 code intact", mem[i], prog[i]);
  endtask

  task automatic t_unknown_op;
    init_all();
    put(0, enc(6'h3F, 1, 2)); put(1, enc(6'h08, 3, 3));
    release_rst();
    to_cycle(5); chk("R7 undefined op timing", mem_addr, 32'd4);
    to_cycle(4); chk("R7 second undefined op timing", mem_addr, 32'd8);
    chk("R7 no writes", 32'(we_count), 32'd0);
    chk("R7 target untouched", mem[130], rmem[130]);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_nop_stream();
    t_single_xadd();
    t_chain();
    t_unknown_op();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule